// File: doc/BRIEF.md
# HDLC 16-bit Frame Check Sequence Engine

This block computes the 16-bit frame check sequence of an HDLC frame, one bit per clock. The framing logic around it removes flags and stuffed zeros and passes in only the payload bits that lie between the opening and the closing flag. Each bit arrives with a valid strobe. A start-of-frame pulse reloads the accumulator. An end-of-frame pulse closes the frame.

A mode input selects one of two uses. In generate mode, an end-of-frame pulse starts a shift-out phase. The engine then presents the 16 inverted check bits serially, highest-order coefficient first, and raises a done strobe with the last bit. In check mode, the received check bits are fed through the accumulator after the payload. At end of frame, the engine raises a one-cycle good or bad pulse, depending on whether the remainder equals the fixed good-frame residue.

Top module: `hdlc_fcs16`

## Requirements
- R1: While `rst_n` is low and in the first cycle after reset, `fcs_vld`, `fcs_done`, `fcs_ok` and `fcs_err` are 0. The accumulator comes out of reset at 16'hFFFF.
- R2: The accumulator `acc[15:0]` holds the polynomial x^16+x^12+x^5+1 in reflected form, so that `acc[0]` is coefficient X15. Each accepted bit b updates it as follows: f = b ^ acc[0], then acc = (acc >> 1) ^ (f ? 16'h8408 : 0).
- R3: A cycle with `bit_vld` low leaves the accumulator unchanged, whatever the value of `bit_in`.
- R4: `sof` loads 16'hFFFF in the same cycle. A bit that is valid in that cycle is folded into the fresh preset.
- R5: In generate mode (`mode_gen`=1), an `eof` sampled at a clock edge first applies any valid bit of that cycle. From the next cycle on, for 16 cycles, `fcs_vld`=1 and `fcs_bit` = ~acc[k] for k = 0..15, so X15 goes out first.
- R6: `fcs_done` is 1 only together with the 16th shifted bit. `fcs_vld` is 0 in the cycle after it.
- R7: In check mode (`mode_gen`=0), the cycle after an `eof` carries exactly one of the two pulses, each lasting one cycle. It is `fcs_ok` if the accumulator, including that cycle's valid bit, equals 16'hF0B8, and `fcs_err` otherwise.
- R8: During the shift-out phase, `bit_vld`, `bit_in` and `eof` have no effect. A `sof` ends the phase at once (`fcs_vld` is 0 in the next cycle) and starts a new frame as in R4.
- R9: `fcs_ok` and `fcs_err` are only ever produced from a check-mode `eof`. In generate mode they stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_gen | input | 1 | 1 = generate check bits, 0 = check received frame |
| sof | input | 1 | Start of frame: reload preset |
| bit_vld | input | 1 | `bit_in` carries a payload bit this cycle |
| bit_in | input | 1 | Serial payload bit |
| eof | input | 1 | End of frame |
| fcs_bit | output | 1 | Serial inverted check bit |
| fcs_vld | output | 1 | `fcs_bit` is valid |
| fcs_done | output | 1 | Last check bit is on `fcs_bit` |
| fcs_ok | output | 1 | One-cycle pulse: frame remainder is good |
| fcs_err | output | 1 | One-cycle pulse: frame remainder is bad |

## Verification
Every 8-bit payload is generated and compared with an arithmetic model that shifts the non-reflected polynomial the other way and reverses the result. A wrong tap, preset, inversion or output order therefore shows up as a mismatch. The same 256 payloads are then fed back with their check bits, once intact, where the residue must match, and once with a single flipped bit, where `fcs_err` must fire. This tells residue detection apart from a plain zero test. Frames of lengths 0 to 40, frames with gaps in `bit_vld`, noise on the inputs during shift-out, and a `sof` that aborts a shift-out cover the ignore, preset and abort rules.

// File: rtl/hdlc_fcs16_pkg.sv
package hdlc_fcs16_pkg;
    localparam int FCS_W = 16;
    localparam int CNT_W = $clog2(FCS_W);

    typedef enum logic {
        PH_ACCUM = 1'b0,
        PH_SHIFT = 1'b1
    } phase_e;

    typedef struct packed {
        phase_e             phase;
        logic [FCS_W-1:0]   acc;
        logic [CNT_W-1:0]   cnt;
        logic               ok;
        logic               err;
    } fcs_state_t;
endpackage

// File: rtl/fcs16_step.sv
module fcs16_step #(
    parameter int                W    = 16,
    parameter logic [W-1:0]      POLY = 16'h8408
) (
    input  logic [W-1:0] acc_i,
    input  logic         bit_i,
    output logic [W-1:0] acc_o
);
    logic fb;
    always_comb begin
        fb    = bit_i ^ acc_i[0];
        acc_o = (acc_i >> 1) ^ (fb ? POLY : '0);
    end
endmodule

// File: rtl/fcs16_match.sv
module fcs16_match #(
    parameter int           W       = 16,
    parameter logic [W-1:0] RESIDUE = 16'hF0B8
) (
    input  logic [W-1:0] acc_i,
    output logic         hit_o
);
    always_comb hit_o = (acc_i == RESIDUE);
endmodule

// File: rtl/hdlc_fcs16.sv
module hdlc_fcs16
    import hdlc_fcs16_pkg::*;
#(
    parameter logic [FCS_W-1:0] POLY    = 16'h8408,
    parameter logic [FCS_W-1:0] PRESET  = 16'hFFFF,
    parameter logic [FCS_W-1:0] RESIDUE = 16'hF0B8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mode_gen,
    input  logic sof,
    input  logic bit_vld,
    input  logic bit_in,
    input  logic eof,
    output logic fcs_bit,
    output logic fcs_vld,
    output logic fcs_done,
    output logic fcs_ok,
    output logic fcs_err
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FCS_W - 1);

    fcs_state_t       st_d, st_q;
    logic [FCS_W-1:0] base_acc, stepped_acc, upd_acc;
    logic             res_hit;

    // A start pulse replaces the stored value with the preset before the step
    assign base_acc = sof ? PRESET : st_q.acc;
    assign upd_acc  = bit_vld ? stepped_acc : base_acc;

    fcs16_step #(.W(FCS_W), .POLY(POLY)) u_step (
        .acc_i (base_acc),
        .bit_i (bit_in),
        .acc_o (stepped_acc)
    );

    fcs16_match #(.W(FCS_W), .RESIDUE(RESIDUE)) u_match (
        .acc_i (upd_acc),
        .hit_o (res_hit)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ok  = 1'b0;
        st_d.err = 1'b0;
        if (st_q.phase == PH_ACCUM || sof) begin
            st_d.phase = PH_ACCUM;
            st_d.acc   = upd_acc;
            st_d.cnt   = '0;
            if (eof) begin
                if (mode_gen) begin
                    st_d.phase = PH_SHIFT;
                end else begin
                    st_d.ok  = res_hit;
                    st_d.err = !res_hit;
                end
            end
        end else begin
            // shift-out phase: payload inputs and eof are ignored
            if (st_q.cnt == LAST_IDX) begin
                st_d.phase = PH_ACCUM;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.phase <= PH_ACCUM;
            st_q.acc   <= PRESET;
            st_q.cnt   <= '0;
            st_q.ok    <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fcs_vld  = (st_q.phase == PH_SHIFT);
    assign fcs_bit  = fcs_vld & ~st_q.acc[st_q.cnt];
    assign fcs_done = fcs_vld && (st_q.cnt == LAST_IDX);
    assign fcs_ok   = st_q.ok;
    assign fcs_err  = st_q.err;
endmodule

// File: rtl/hdlc_fcs16_chk.sv
module hdlc_fcs16_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_gen,
    input logic sof,
    input logic bit_vld,
    input logic bit_in,
    input logic eof,
    input logic fcs_bit,
    input logic fcs_vld,
    input logic fcs_done,
    input logic fcs_ok,
    input logic fcs_err
);
    AST_OK_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(fcs_ok && fcs_err)); // R7
    AST_RESULT_FROM_CHECK_EOF: assert property (@(posedge clk) disable iff (!rst_n)
        (fcs_ok || fcs_err) |-> $past(eof && !mode_gen)); // R9
    AST_DONE_WITH_VLD: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_done |-> fcs_vld); // R6
    AST_DONE_ENDS_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        fcs_done |=> !fcs_vld); // R6
    AST_SHIFT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (eof && mode_gen && !fcs_vld) |=> fcs_vld); // R5
    AST_SHIFT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fcs_vld && !fcs_done && !sof) |=> fcs_vld); // R8
    AST_SOF_ABORTS: assert property (@(posedge clk) disable iff (!rst_n)
        (fcs_vld && sof && !eof) |=> !fcs_vld); // R8
    AST_BIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !fcs_vld |-> !fcs_bit); // R5
endmodule

bind hdlc_fcs16 hdlc_fcs16_chk u_chk (.*);

// File: tb/hdlc_fcs16_bench.sv
module hdlc_fcs16_bench;
    logic clk = 1'b0;
    logic rst_n, mode_gen, sof, bit_vld, bit_in, eof;
    logic fcs_bit, fcs_vld, fcs_done, fcs_ok, fcs_err;
    int checks = 0, fails = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    hdlc_fcs16 u_hdlc_fcs16 (.*);

    task automatic check(input bit cond, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Non-reflected reference: shift left, taps 0x1021; X15 = c[15]
    function automatic logic [15:0] model_c(input logic [63:0] d, input int n);
        logic [15:0] c = 16'hFFFF;
        for (int i = 0; i < n; i++) begin
            logic f = d[i] ^ c[15];
            c = {c[14:0], 1'b0} ^ (f ? 16'h1021 : 16'h0000);
        end
        return c;
    endfunction

    function automatic logic [15:0] exp_serial(input logic [15:0] c);
        logic [15:0] e;
        for (int k = 0; k < 16; k++) e[k] = ~c[15-k];
        return e;
    endfunction

    task automatic idle_inputs();
        sof = 0; eof = 0; bit_vld = 0; bit_in = 0;
    endtask

    // collect 16 serial bits; optional noise on ignored inputs (R8)
    task automatic shift_out(output logic [15:0] got, output int bad, input bit noise);
        bad = 0;
        for (int k = 0; k < 16; k++) begin
            if (!fcs_vld || fcs_done != (k == 15) || fcs_ok || fcs_err) bad++;
            got[k] = fcs_bit;
            if (noise) begin bit_vld = 1; bit_in = k[1]; eof = k[0]; end
            @(negedge clk);
        end
        idle_inputs();
        if (fcs_vld) bad++;
    endtask

    task automatic run_gen(input logic [63:0] d, input int n, input bit noise, input string req);
        logic [15:0] got;
        int bad;
        mode_gen = 1;
        if (n == 0) begin
            sof = 1; eof = 1; bit_vld = 0; @(negedge clk);
        end else begin
            for (int i = 0; i < n; i++) begin
                sof = (i == 0); bit_vld = 1; bit_in = d[i]; eof = (i == n - 1);
                @(negedge clk);
            end
        end
        idle_inputs();
        shift_out(got, bad, noise);
        check(got === exp_serial(model_c(d, n)), req, {16'h0, got}, {16'h0, exp_serial(model_c(d, n))});
        check(bad == 0, "R6 vld/done framing", bad, 0);
    endtask

    task automatic run_chk(input logic [63:0] d, input int n, input int flip, input string req);
        logic [63:0] v = d;
        logic [15:0] e = exp_serial(model_c(d, n));
        for (int k = 0; k < 16; k++) v[n+k] = e[k];
        if (flip >= 0) v[flip] = ~v[flip];
        mode_gen = 0;
        for (int i = 0; i < n + 16; i++) begin
            sof = (i == 0); bit_vld = 1; bit_in = v[i]; eof = (i == n + 15);
            @(negedge clk);
        end
        idle_inputs();
        check(fcs_ok == (flip < 0) && fcs_err == (flip >= 0), req,
              {30'h0, fcs_ok, fcs_err}, {30'h0, flip < 0, flip >= 0});
        @(negedge clk);
        check(!fcs_ok && !fcs_err, "R7 one-cycle pulse", {30'h0, fcs_ok, fcs_err}, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mode_gen = 1; idle_inputs();
        repeat (3) @(negedge clk);
        check(!fcs_vld && !fcs_done && !fcs_ok && !fcs_err, "R1 reset outputs",
              {28'h0, fcs_vld, fcs_done, fcs_ok, fcs_err}, 0);
        rst_n = 1;
        @(negedge clk);
        check(!fcs_vld && !fcs_ok && !fcs_err, "R1 first cycle", {29'h0, fcs_vld, fcs_ok, fcs_err}, 0);
        // R1: eof without sof uses the reset preset -> empty-frame check bits
        eof = 1; @(negedge clk); eof = 0;
        begin
            logic [15:0] got; int bad;
            shift_out(got, bad, 0);
            check(got === exp_serial(16'hFFFF), "R1 preset after reset", {16'h0, got}, {16'h0, exp_serial(16'hFFFF)});
        end
        // R2 R5: exhaustive 8-bit payloads in generate mode
        for (int p = 0; p < 256; p++) run_gen(64'(p), 8, 0, "R2 R5 gen 8-bit sweep");
        // R4: lengths 0..40 incl. empty and one-bit frames
        for (int n = 0; n <= 40; n++) run_gen(64'hA5C3_1E7F_0B92_D468 ^ 64'(n * 37), n, 0, "R4 gen length sweep");
        // R8: noise during shift-out is ignored
        run_gen(64'h3C, 8, 1, "R8 noise ignored in shift");
        // R7: exhaustive check-mode, clean and with one flipped bit
        for (int p = 0; p < 256; p++) begin
            run_chk(64'(p), 8, -1, "R7 good residue");
            run_chk(64'(p), 8, p % 24, "R7 corrupted frame");
        end
        // R3: frame with gaps; bits during gaps carry garbage
        begin
            logic [63:0] d = 64'h0000_0000_00D3_6B2E;
            logic [15:0] got; int bad; int idx = 0;
            mode_gen = 1;
            for (int c = 0; c < 48; c++) begin
                sof = (c == 0);
                bit_vld = (c % 3 != 1);
                bit_in = bit_vld ? d[idx] : ~d[idx];
                eof = (c == 47);
                if (bit_vld) idx++;
                @(negedge clk);
            end
            idle_inputs();
            shift_out(got, bad, 0);
            check(got === exp_serial(model_c(d, idx)), "R3 gaps ignored", {16'h0, got}, {16'h0, exp_serial(model_c(d, idx))});
        end
        // R8: sof aborts a shift-out
        mode_gen = 1;
        sof = 1; bit_vld = 1; bit_in = 1; eof = 1; @(negedge clk);
        idle_inputs();
        repeat (5) @(negedge clk);
        sof = 1; @(negedge clk); sof = 0;
        check(!fcs_vld, "R8 sof aborts shift", {31'h0, fcs_vld}, 0);
        run_gen(64'h96, 8, 0, "R8 frame after abort");
        // R9: no results in generate mode
        mode_gen = 1; sof = 1; bit_vld = 1; eof = 1; @(negedge clk); idle_inputs();
        check(!fcs_ok && !fcs_err && fcs_vld, "R9 no result in gen mode", {29'h0, fcs_ok, fcs_err, fcs_vld}, 1);
        repeat (20) @(negedge clk);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule